// File: doc/BRIEF.md
# Debug Trigger Comparator Bank

This block watches every instruction fetch, load and store that a hart performs and compares it against a small bank of programmable debug triggers. Each trigger holds a control word and a compare value. The control word selects whether the access address or the access data is compared, which of six compare modes applies, and which operation types and privilege levels the trigger cares about. Adjacent triggers can be chained, so that a hit is reported only when every trigger in the chain matches the same access.

The bank is programmed through a simple indexed write port. Each access is presented with a one-cycle valid strobe. One cycle later the block reports whether a trigger fired, the index of the lowest trigger that completed a match, and that trigger's action code. Acting on the result, such as halting or raising a breakpoint exception, is left to the surrounding logic.

The block has no state machine. Its only sequential elements are the trigger registers and the registered result. The compare path runs through three stages: an eligibility mask per trigger, one comparator per trigger, and a chain and priority resolver that scans the triggers from index 0 upward.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset every trigger holds action 0 (none), the compare values are zero, and the outputs are zero. No access produces a hit until a trigger is programmed. A write with `wr_sel`=0 loads the control word: bits [2:0] action (0 none, 1 breakpoint, 2 halt, 3 trace on, 4 trace off, 5 trace note), bits [5:3] mode, bit 6 execute enable, bit 7 load enable, bit 8 store enable, bits [12:9] privilege enables (bit 9 U, 10 S, 11 H, 12 M), bit 13 select, bit 14 chain. A write with `wr_sel`=1 loads the compare value. A write takes effect at the next clock edge.
- R2: `hit_o`, `hit_idx_o` and `hit_act_o` are registered. They reflect the access strobed in the previous cycle. After a cycle without `acc_valid`, or with an access that hits nothing, all three are zero.
- R3: A trigger is eligible only if its action is non-zero, its enable bit for `acc_op` is set (0 execute, 1 load, 2 store; code 3 matches no trigger), and its enable bit for `acc_priv` is set (0 U, 1 S, 2 H, 3 M).
- R4: While `dbg_cause_active` is high, no hit is reported for that access.
- R5: When the select bit is 1 the trigger compares `acc_data`. When it is 0 the trigger compares the address.
- R6: Mode 0 (equal) fires when the compared value equals the compare value.
- R7: Mode 2 fires when the value is greater than or equal to the compare value. Mode 3 fires when the value is less than the compare value. Both comparisons are unsigned.
- R8: Mode 1 (aligned range) counts the n contiguous ones at bit 0 of the compare value. It fires when the value and the compare value agree in every bit above those n bits. An all-ones compare value matches any value.
- R9: Mode 4 (low mask) takes its mask from the upper half of the compare value. It fires when (value & mask) equals (compare & mask).
- R10: Mode 5 (high mask) uses the same mask. It fires when (upper half of value & mask) equals (compare & mask). Modes 6 and 7 never fire.
- R11: A trigger with its chain bit set fires only if the trigger below it matched and was armed. A matching trigger whose successor has its chain bit set reports nothing and only arms the successor. An ineligible or mismatching trigger disarms the chain, and a chain bit on trigger 0 prevents it from ever firing.
- R12: When several triggers complete a match, the lowest index is reported together with that trigger's action.
- R13: Address bits at and above XLEN are ignored: only `acc_addr[XLEN-1:0]` is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Trigger register write strobe |
| wr_idx | input | IDX_W | Trigger selected by the write |
| wr_sel | input | 1 | 0 = control word, 1 = compare value |
| wr_data | input | XLEN | Write data |
| acc_valid | input | 1 | Access strobe |
| acc_op | input | 2 | Operation type of the access |
| acc_priv | input | 2 | Current privilege level |
| acc_addr | input | ADDR_W | Access address |
| acc_data | input | XLEN | Access data |
| dbg_cause_active | input | 1 | Suppresses all hits while high |
| hit_o | output | 1 | A trigger fired on the previous access |
| hit_idx_o | output | IDX_W | Index of the reported trigger |
| hit_act_o | output | 3 | Action code of the reported trigger |

## Verification
Every result is due exactly one clock after the edge that captures the access strobe. A register write is visible to the first access captured after the edge that takes the write. The bench drives inputs on a falling edge, lets one rising edge capture them, and reads the outputs on the following falling edge, so each check falls one capture edge after its stimulus. To show that a result drops back to zero, an idle cycle is inserted after a hit and the outputs are read one cycle later.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam int CTRL_W = 15;

    localparam logic [1:0] OP_EXEC  = 2'd0;
    localparam logic [1:0] OP_LOAD  = 2'd1;
    localparam logic [1:0] OP_STORE = 2'd2;

    localparam logic [2:0] ACT_NONE = 3'd0;

    localparam logic [2:0] MODE_EQ    = 3'd0;
    localparam logic [2:0] MODE_RANGE = 3'd1;
    localparam logic [2:0] MODE_GE    = 3'd2;
    localparam logic [2:0] MODE_LT    = 3'd3;
    localparam logic [2:0] MODE_MLO   = 3'd4;
    localparam logic [2:0] MODE_MHI   = 3'd5;

    typedef struct packed {
        logic       chain;
        logic       sel;
        logic [3:0] priv_en;
        logic       st_en;
        logic       ld_en;
        logic       ex_en;
        logic [2:0] mode;
        logic [2:0] act;
    } trig_ctrl_t;

endpackage

// File: rtl/dbg_trig_bank.sv
module dbg_trig_bank
    import dbg_trig_pkg::*;
#(
    parameter int NTRIG = 4,
    parameter int XLEN  = 32,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_sel,
    input  logic [XLEN-1:0]      wr_data,
    output trig_ctrl_t           ctrl_q [NTRIG],
    output logic [XLEN-1:0]      cmp_q  [NTRIG]
);

    for (genvar t = 0; t < NTRIG; t++) begin : g_slot
        logic hit_me;
        assign hit_me = wr_en && (wr_idx == IDX_W'(t));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[t] <= '0;
                cmp_q[t]  <= '0;
            end else if (hit_me) begin
                if (wr_sel) begin
                    cmp_q[t] <= wr_data;
                end else begin
                    ctrl_q[t] <= trig_ctrl_t'(wr_data[CTRL_W-1:0]);
                end
            end
        end
    end

endmodule

// File: rtl/dbg_trig_cmp.sv
module dbg_trig_cmp
    import dbg_trig_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      mode,
    input  logic [XLEN-1:0] cmp,
    input  logic [XLEN-1:0] value,
    output logic            match
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] range_mask;
    logic [XLEN-1:0] half_mask;
    logic [XLEN-1:0] value_hi;

    // A bit survives the range mask unless every compare bit at and below it is one.
    always_comb begin
        logic run;
        run = 1'b1;
        for (int b = 0; b < XLEN; b++) begin
            run           = run & cmp[b];
            range_mask[b] = ~run;
        end
    end

    assign half_mask = cmp >> HALF;
    assign value_hi  = value >> HALF;

    always_comb begin
        unique case (mode)
            MODE_EQ:    match = (value == cmp);
            MODE_RANGE: match = ((value & range_mask) == (cmp & range_mask));
            MODE_GE:    match = (value >= cmp);
            MODE_LT:    match = (value < cmp);
            MODE_MLO:   match = ((value & half_mask) == (cmp & half_mask));
            MODE_MHI:   match = ((value_hi & half_mask) == (cmp & half_mask));
            default:    match = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbg_trig_sel.sv
module dbg_trig_sel #(
    parameter int NTRIG = 4,
    parameter int IDX_W = 2
) (
    input  logic [NTRIG-1:0] elig,
    input  logic [NTRIG-1:0] match,
    input  logic [NTRIG-1:0] chain,
    input  logic             cause_active,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [NTRIG-1:0] next_chain;
    assign next_chain = chain >> 1;

    always_comb begin
        logic armed;
        logic done;
        logic any;
        armed = 1'b0;
        done  = 1'b0;
        any   = 1'b0;
        idx   = '0;
        for (int i = 0; i < NTRIG; i++) begin
            if (!done) begin
                if (!elig[i]) begin
                    armed = 1'b0;
                end else if (chain[i] && !armed) begin
                    armed = 1'b0;
                end else if (!match[i]) begin
                    armed = 1'b0;
                end else if (next_chain[i]) begin
                    armed = 1'b1;
                end else begin
                    any  = 1'b1;
                    idx  = IDX_W'(i);
                    done = 1'b1;
                end
            end
        end
        found = any && !cause_active;
    end

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter int NTRIG  = 4,
    parameter int XLEN   = 32,
    parameter int ADDR_W = 64,
    localparam int IDX_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_sel,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              acc_valid,
    input  logic [1:0]        acc_op,
    input  logic [1:0]        acc_priv,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [XLEN-1:0]   acc_data,
    input  logic              dbg_cause_active,
    output logic              hit_o,
    output logic [IDX_W-1:0]  hit_idx_o,
    output logic [2:0]        hit_act_o
);

    trig_ctrl_t        ctrl_q [NTRIG];
    logic [XLEN-1:0]   cmp_q  [NTRIG];
    logic [XLEN-1:0]   addr_x;
    logic [NTRIG-1:0]  elig_v;
    logic [NTRIG-1:0]  match_v;
    logic [NTRIG-1:0]  chain_v;
    logic              found;
    logic [IDX_W-1:0]  found_idx;

    assign addr_x = acc_addr[XLEN-1:0];

    if (ADDR_W > XLEN) begin : g_addr_hi
        logic unused_addr_hi;
        assign unused_addr_hi = ^acc_addr[ADDR_W-1:XLEN];
    end

    dbg_trig_bank #(
        .NTRIG (NTRIG),
        .XLEN  (XLEN),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .cmp_q   (cmp_q)
    );

    for (genvar t = 0; t < NTRIG; t++) begin : g_trig
        logic            op_ok;
        logic [XLEN-1:0] value;

        always_comb begin
            unique case (acc_op)
                OP_EXEC:  op_ok = ctrl_q[t].ex_en;
                OP_LOAD:  op_ok = ctrl_q[t].ld_en;
                OP_STORE: op_ok = ctrl_q[t].st_en;
                default:  op_ok = 1'b0;
            endcase
        end

        assign elig_v[t]  = (ctrl_q[t].act != ACT_NONE) && op_ok
                            && ctrl_q[t].priv_en[acc_priv];
        assign value      = ctrl_q[t].sel ? acc_data : addr_x;
        assign chain_v[t] = ctrl_q[t].chain;

        dbg_trig_cmp #(
            .XLEN (XLEN)
        ) u_cmp (
            .mode  (ctrl_q[t].mode),
            .cmp   (cmp_q[t]),
            .value (value),
            .match (match_v[t])
        );
    end

    dbg_trig_sel #(
        .NTRIG (NTRIG),
        .IDX_W (IDX_W)
    ) u_sel (
        .elig         (elig_v),
        .match        (match_v),
        .chain        (chain_v),
        .cause_active (dbg_cause_active),
        .found        (found),
        .idx          (found_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_o     <= 1'b0;
            hit_idx_o <= '0;
            hit_act_o <= ACT_NONE;
        end else if (acc_valid && found) begin
            hit_o     <= 1'b1;
            hit_idx_o <= found_idx;
            hit_act_o <= ctrl_q[found_idx].act;
        end else begin
            hit_o     <= 1'b0;
            hit_idx_o <= '0;
            hit_act_o <= ACT_NONE;
        end
    end

endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [1:0] acc_op,
    input logic       dbg_cause_active,
    input logic       hit_o,
    input logic [2:0] hit_act_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hit_o && hit_act_o == 3'd0);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !hit_o && hit_act_o == 3'd0);

    // R3
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_op == 2'd3 |=> !hit_o);

    // R3
    live_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> hit_act_o != 3'd0);

    // R4
    cause_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && dbg_cause_active |=> !hit_o);

endmodule

bind dbg_trig_unit dbg_trig_unit_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .acc_valid        (acc_valid),
    .acc_op           (acc_op),
    .dbg_cause_active (dbg_cause_active),
    .hit_o            (hit_o),
    .hit_act_o        (hit_act_o)
);

// File: tb/dbg_trig_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_trig_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_op = '0;
    logic [1:0]  acc_priv = '0;
    logic [63:0] acc_addr = '0;
    logic [31:0] acc_data = '0;
    logic        dbg_cause_active = 1'b0;
    logic        hit_o;
    logic [1:0]  hit_idx_o;
    logic [2:0]  hit_act_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dbg_trig_unit #(.NTRIG(4), .XLEN(32), .ADDR_W(64)) dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx),
        .wr_sel (wr_sel), .wr_data (wr_data), .acc_valid (acc_valid),
        .acc_op (acc_op), .acc_priv (acc_priv), .acc_addr (acc_addr),
        .acc_data (acc_data), .dbg_cause_active (dbg_cause_active),
        .hit_o (hit_o), .hit_idx_o (hit_idx_o), .hit_act_o (hit_act_o)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  priv;
        logic        cause;
        logic [63:0] addr;
        logic [31:0] data;
        logic        hit;
        logic [1:0]  idx;
        logic [2:0]  act;
        logic [31:0] tag;
    } vec_t;

    // op: 0 exec 1 load 2 store 3 none; priv: 0 U 1 S 2 H 3 M
    localparam vec_t VECS [17] = '{
        '{2'd0, 2'd3, 1'b0, 64'h1000, 32'h0, 1'b1, 2'd0, 3'd2, "R6"},
        '{2'd0, 2'd3, 1'b0, 64'h1004, 32'h0, 1'b0, 2'd0, 3'd0, "R6"},
        '{2'd0, 2'd0, 1'b0, 64'hFFFFFFFF_00001000, 32'h0, 1'b1, 2'd0, 3'd2, "R13"},
        '{2'd1, 2'd3, 1'b0, 64'h5000, 32'h90000000, 1'b1, 2'd1, 3'd1, "R5"},
        '{2'd1, 2'd3, 1'b0, 64'h90000000, 32'h10, 1'b0, 2'd0, 3'd0, "R5"},
        '{2'd1, 2'd1, 1'b0, 64'h5000, 32'h90000000, 1'b0, 2'd0, 3'd0, "R3"},
        '{2'd1, 2'd1, 1'b0, 64'h2005, 32'h0, 1'b1, 2'd2, 3'd3, "R8"},
        '{2'd1, 2'd0, 1'b0, 64'h2000, 32'h0, 1'b1, 2'd2, 3'd3, "R8"},
        '{2'd1, 2'd0, 1'b0, 64'h2008, 32'h0, 1'b0, 2'd0, 3'd0, "R8"},
        '{2'd1, 2'd3, 1'b0, 64'h2005, 32'h90000000, 1'b1, 2'd1, 3'd1, "R12"},
        '{2'd2, 2'd0, 1'b0, 64'hFF, 32'h0, 1'b1, 2'd3, 3'd5, "R7"},
        '{2'd2, 2'd0, 1'b0, 64'h100, 32'h0, 1'b0, 2'd0, 3'd0, "R7"},
        '{2'd2, 2'd3, 1'b0, 64'h50, 32'h80000000, 1'b1, 2'd1, 3'd1, "R7"},
        '{2'd2, 2'd3, 1'b0, 64'h50, 32'h7FFFFFFF, 1'b0, 2'd0, 3'd0, "R3"},
        '{2'd0, 2'd3, 1'b1, 64'h1000, 32'h0, 1'b0, 2'd0, 3'd0, "R4"},
        '{2'd3, 2'd3, 1'b0, 64'h1000, 32'h0, 1'b0, 2'd0, 3'd0, "R3"},
        '{2'd0, 2'd2, 1'b0, 64'h1000, 32'h0, 1'b1, 2'd0, 3'd2, "R3"}
    };

    function automatic logic [31:0] ctrl_w(input logic [2:0] act, input logic [2:0] mode,
                                           input logic ex, input logic ld, input logic st,
                                           input logic [3:0] priv, input logic sel,
                                           input logic chain);
        return {17'd0, chain, sel, priv, st, ld, ex, mode, act};
    endfunction

    task automatic wr(input logic [1:0] idx, input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_out(input logic eh, input logic [1:0] ei, input logic [2:0] ea,
                              input logic [31:0] tag);
        total++;
        if (hit_o !== eh || hit_idx_o !== ei || hit_act_o !== ea) begin
            bad++;
            $display("FAIL %s: hit=%0d idx=%0d act=%0d expected hit=%0d idx=%0d act=%0d",
                     tag, hit_o, hit_idx_o, hit_act_o, eh, ei, ea);
        end
    endtask

    task automatic access(input logic [1:0] op, input logic [1:0] priv, input logic cause,
                          input logic [63:0] addr, input logic [31:0] data,
                          input logic eh, input logic [1:0] ei, input logic [2:0] ea,
                          input logic [31:0] tag);
        @(negedge clk);
        acc_op = op; acc_priv = priv; dbg_cause_active = cause;
        acc_addr = addr; acc_data = data; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; dbg_cause_active = 1'b0;
        expect_out(eh, ei, ea, tag);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out(1'b0, 2'd0, 3'd0, "R1");
        rst_n = 1'b1;
        // R1: unprogrammed bank never fires, even with a zero address
        access(2'd0, 2'd3, 1'b0, 64'h0, 32'h0, 1'b0, 2'd0, 3'd0, "R1");

        wr(2'd0, 1'b0, ctrl_w(3'd2, 3'd0, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b0));
        wr(2'd0, 1'b1, 32'h1000);
        wr(2'd1, 1'b0, ctrl_w(3'd1, 3'd2, 1'b0, 1'b1, 1'b1, 4'b1000, 1'b1, 1'b0));
        wr(2'd1, 1'b1, 32'h80000000);
        wr(2'd2, 1'b0, ctrl_w(3'd3, 3'd1, 1'b0, 1'b1, 1'b0, 4'b1111, 1'b0, 1'b0));
        wr(2'd2, 1'b1, 32'h2007);
        wr(2'd3, 1'b0, ctrl_w(3'd5, 3'd3, 1'b0, 1'b0, 1'b1, 4'b0011, 1'b0, 1'b0));
        wr(2'd3, 1'b1, 32'h100);

        for (int v = 0; v < 17; v++) begin
            access(VECS[v].op, VECS[v].priv, VECS[v].cause, VECS[v].addr, VECS[v].data,
                   VECS[v].hit, VECS[v].idx, VECS[v].act, VECS[v].tag);
        end

        // R2: a hit followed by an idle cycle drops back to zero
        access(2'd0, 2'd3, 1'b0, 64'h1000, 32'h0, 1'b1, 2'd0, 3'd2, "R2");
        @(negedge clk);
        expect_out(1'b0, 2'd0, 3'd0, "R2");

        // R9: low mask, mask 0x00F0 from the upper half
        wr(2'd0, 1'b0, ctrl_w(3'd2, 3'd4, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b0));
        wr(2'd0, 1'b1, 32'h00F00030);
        access(2'd0, 2'd3, 1'b0, 64'h12345637, 32'h0, 1'b1, 2'd0, 3'd2, "R9");
        access(2'd0, 2'd3, 1'b0, 64'h12345647, 32'h0, 1'b0, 2'd0, 3'd0, "R9");

        // R10: high mask compares the upper half of the address
        wr(2'd0, 1'b0, ctrl_w(3'd2, 3'd5, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b0));
        access(2'd0, 2'd3, 1'b0, 64'h00350000, 32'h0, 1'b1, 2'd0, 3'd2, "R10");
        access(2'd0, 2'd3, 1'b0, 64'h00450030, 32'h0, 1'b0, 2'd0, 3'd0, "R10");
        // R10: mode 7 never fires
        wr(2'd0, 1'b0, ctrl_w(3'd2, 3'd7, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b0));
        access(2'd0, 2'd3, 1'b0, 64'h00350000, 32'h0, 1'b0, 2'd0, 3'd0, "R10");

        // R8: an all-ones compare value matches anything
        wr(2'd0, 1'b0, ctrl_w(3'd2, 3'd1, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b0));
        wr(2'd0, 1'b1, 32'hFFFFFFFF);
        access(2'd0, 2'd3, 1'b0, 64'hDEADBEEF, 32'h0, 1'b1, 2'd0, 3'd2, "R8");

        // R11: chain of trigger 0 (address 0x40) and trigger 1 (data 0xAB)
        wr(2'd2, 1'b0, 32'h0);
        wr(2'd3, 1'b0, 32'h0);
        wr(2'd0, 1'b0, ctrl_w(3'd2, 3'd0, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b0));
        wr(2'd0, 1'b1, 32'h40);
        wr(2'd1, 1'b0, ctrl_w(3'd1, 3'd0, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b1, 1'b1));
        wr(2'd1, 1'b1, 32'hAB);
        access(2'd0, 2'd0, 1'b0, 64'h40, 32'hAB, 1'b1, 2'd1, 3'd1, "R11");
        access(2'd0, 2'd0, 1'b0, 64'h40, 32'h0,  1'b0, 2'd0, 3'd0, "R11");
        access(2'd0, 2'd0, 1'b0, 64'h44, 32'hAB, 1'b0, 2'd0, 3'd0, "R11");
        // R11: trigger 0 ineligible at U breaks the chain
        wr(2'd0, 1'b0, ctrl_w(3'd2, 3'd0, 1'b1, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b0));
        access(2'd0, 2'd0, 1'b0, 64'h40, 32'hAB, 1'b0, 2'd0, 3'd0, "R11");
        // R11: chain bit on trigger 0 keeps the whole chain silent
        wr(2'd0, 1'b0, ctrl_w(3'd2, 3'd0, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b1));
        access(2'd0, 2'd0, 1'b0, 64'h40, 32'hAB, 1'b0, 2'd0, 3'd0, "R11");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule